// File: doc/BRIEF.md
# Half-Flash ADC Strobe Sequencer

This block drives an external two-step (half-flash) 8-bit analog-to-digital converter over its parallel, processor-style bus. It generates chip select, write and read strobes. It watches the converter's end-of-conversion and ready lines through a synchronizer and captures the 8-bit data bus. Each result is returned on a simple port: a start pulse, a busy flag, and a data byte with a one-cycle valid strobe. All minimum strobe and delay times are given in nanoseconds. They are converted to clock cycles with a ceiling, so no phase is ever shorter than the converter needs.

A mode input, sampled at start, selects the protocol.

- **Read-only mode (mode low):** a single long read strobe covers the whole conversion. The converter times both half-conversions internally.
- **Write-then-read mode (mode high):** a write strobe of minimum width starts the conversion. After a minimum gap, a read strobe collects the result. The read is issued either at the fixed minimum delay or, when requested, only after the converter signals completion.

A timeout bound ends any wait on the converter. The data is then captured anyway and flagged as an error.

Top module: `adc_seq`

## Requirements
- R1: During and after reset, `adc_cs_no`, `adc_wr_no` and `adc_rd_no` are high, and `busy_o`, `valid_o` and `err_o` are low.
- R2: Chip select is low whenever the write or read strobe is low. In read-only mode (`mode_i`=0) the write strobe never goes low. After the cycle that accepts `start_i`, the chip select and read strobe go low together.
- R3: In read-only mode the bus is captured at the first clock edge where the synchronized ready input is high and either the synchronized end-of-conversion input is low or the read strobe has been low for RD_CYC=ceil(T_RD_NS/CLK_NS) cycles. Capture while ready is low happens only on timeout.
- R4: In write-then-read mode the write strobe stays low for exactly WR_CYC=ceil(T_WR_NS/CLK_NS) cycles.
- R5: In write-then-read mode the read strobe falls no sooner than GAP_CYC=ceil(T_GAP_NS/CLK_NS) cycles after the write strobe rises. With `irq_wait_i`=0 it falls exactly GAP_CYC cycles after the rise.
- R6: With `irq_wait_i`=1 in write-then-read mode, the read strobe falls on the first edge where the synchronized end-of-conversion input is low, but not before the GAP_CYC bound.
- R7: In write-then-read mode the read strobe is held low for ACC_CYC=ceil(T_ACC_NS/CLK_NS) cycles, and the bus is captured at the edge that ends it.
- R8: `valid_o` is high for exactly one cycle, in the cycle after capture. `data_o` then holds the captured byte.
- R9: If a wait on the converter lasts TMO_CYC cycles without completing, the bus is captured anyway and `err_o` is high together with `valid_o`. Otherwise `err_o` is low with `valid_o`.
- R10: After capture, all three strobes stay high for REC_CYC=max(1,ceil(T_REC_NS/CLK_NS)) cycles. `busy_o` is high from the cycle after start is accepted until that recovery period ends.
- R11: A `start_i` pulse that arrives while `busy_o` is high is ignored. It does not change the running conversion and does not launch another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Protocol select: 0 read-only, 1 write-then-read |
| irq_wait_i | input | 1 | Write-then-read: 1 waits for end-of-conversion before the read |
| start_i | input | 1 | Start pulse; honoured only when idle |
| busy_o | output | 1 | Conversion sequence in progress |
| data_o | output | 8 | Captured result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| err_o | output | 1 | Result was captured on timeout (with valid_o) |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_wr_no | output | 1 | Converter write strobe, active low |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| adc_int_ni | input | 1 | Converter end-of-conversion, active low |
| adc_rdy_i | input | 1 | Converter ready; low means busy |
| adc_db_i | input | 8 | Converter data bus |

## Verification
A wrong phase state or counter limit shows at the strobe pins within the phase in which it occurs. The result is a write pulse of the wrong width, a read strobe that falls too early after the write strobe rises, or a chip select that lifts under an active strobe. A wrong capture decision shows one cycle later, as a `valid_o` in the wrong cycle, a byte that differs from what the modelled converter drove, or an error flag that does not match the timeout condition. A stuck sequence shows as `busy_o` that does not fall exactly REC_CYC cycles after the valid strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RO_RD,
    ST_WR_LOW,
    ST_WR_WAIT,
    ST_RD_LOW,
    ST_REC
  } seq_st_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned    W       = 2,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (STAGES <= 1) begin : g_one
    logic [W-1:0] s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= RST_VAL;
      else         s_q <= d_i;
    end
    assign q_o = s_q;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= {STAGES{RST_VAL}};
      else         s_q <= {s_q[STAGES-2:0], d_i};
    end
    assign q_o = s_q[STAGES-1];
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;

  // saturating phase counter, restarted on every phase change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CW      = 9,
  parameter int unsigned WR_CYC  = 75,
  parameter int unsigned GAP_CYC = 75,
  parameter int unsigned RD_CYC  = 200,
  parameter int unsigned ACC_CYC = 25,
  parameter int unsigned REC_CYC = 13,
  parameter int unsigned TMO_CYC = 400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          irq_wait_i,
  input  logic          int_ni,
  input  logic          rdy_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          lat_o,
  output logic          lat_err_o,
  output logic          ro_o,
  output logic          busy_o,
  output logic          cs_no,
  output logic          wr_no,
  output logic          rd_no
);

  localparam logic [CW-1:0] WR_LAST  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

  seq_st_e state_q, state_d;
  logic    mode_q, irq_q, pend_q;
  logic    set_pend;
  logic    cs_q, wr_q, rd_q;
  logic    tmo_hit;

  assign tmo_hit = (cnt_i >= TMO_LAST);

  always_comb begin
    state_d   = state_q;
    clr_o     = 1'b0;
    lat_o     = 1'b0;
    lat_err_o = 1'b0;
    set_pend  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = mode_i ? ST_WR_LOW : ST_RO_RD;
          clr_o   = 1'b1;
        end
      end
      ST_RO_RD: begin
        if (rdy_i && (!int_ni || cnt_i >= RD_LAST)) begin
          lat_o   = 1'b1;
          state_d = ST_REC;
          clr_o   = 1'b1;
        end else if (tmo_hit) begin
          lat_o     = 1'b1;
          lat_err_o = 1'b1;
          state_d   = ST_REC;
          clr_o     = 1'b1;
        end
      end
      ST_WR_LOW: begin
        if (cnt_i >= WR_LAST) begin
          state_d = ST_WR_WAIT;
          clr_o   = 1'b1;
        end
      end
      ST_WR_WAIT: begin
        if (cnt_i >= GAP_LAST && (!irq_q || !int_ni)) begin
          state_d = ST_RD_LOW;
          clr_o   = 1'b1;
        end else if (irq_q && tmo_hit) begin
          set_pend = 1'b1;
          state_d  = ST_RD_LOW;
          clr_o    = 1'b1;
        end
      end
      ST_RD_LOW: begin
        if (cnt_i >= ACC_LAST) begin
          lat_o     = 1'b1;
          lat_err_o = pend_q;
          state_d   = ST_REC;
          clr_o     = 1'b1;
        end
      end
      ST_REC: begin
        if (cnt_i >= REC_LAST) begin
          state_d = ST_IDLE;
          clr_o   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        clr_o   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      irq_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        mode_q <= mode_i;
        irq_q  <= irq_wait_i;
        pend_q <= 1'b0;
      end else if (set_pend) begin
        pend_q <= 1'b1;
      end
    end
  end

  // strobes registered from the next-state decode: glitch-free pins, no added latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b1;
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      cs_q <= !(state_d inside {ST_RO_RD, ST_WR_LOW, ST_WR_WAIT, ST_RD_LOW});
      wr_q <= !(state_d == ST_WR_LOW);
      rd_q <= !(state_d inside {ST_RO_RD, ST_RD_LOW});
    end
  end

  assign cs_no  = cs_q;
  assign wr_no  = wr_q;
  assign rd_no  = rd_q;
  assign busy_o = (state_q != ST_IDLE);
  assign ro_o   = !mode_q;

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_REC) |=> busy_o); // R11

  AST_RO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ro_o && busy_o) |-> wr_no); // R2

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lat_i,
  input  logic          lat_err_i,
  input  logic          ro_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] db_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          err_o
);

  logic [DW-1:0] data_q;
  logic          valid_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= lat_i;
      err_q   <= lat_i && lat_err_i;
      if (lat_i) data_q <= db_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_NO_LATCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_i && ro_i && !rdy_i) |-> lat_err_i); // R3

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8

  AST_ERR_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o); // R9

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_i |=> $stable(data_o)); // R8

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned T_RD_NS     = 1600,
  parameter int unsigned T_WR_NS     = 600,
  parameter int unsigned T_GAP_NS    = 600,
  parameter int unsigned T_ACC_NS    = 200,
  parameter int unsigned T_REC_NS    = 100,
  parameter int unsigned TMO_CYC     = 400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       irq_wait_i,
  input  logic       start_i,
  output logic       busy_o,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       err_o,
  output logic       adc_cs_no,
  output logic       adc_wr_no,
  output logic       adc_rd_no,
  input  logic       adc_int_ni,
  input  logic       adc_rdy_i,
  input  logic [7:0] adc_db_i
);

  localparam int unsigned WR_CYC  = umax(1, ns2cyc(T_WR_NS, CLK_NS));
  localparam int unsigned GAP_CYC = umax(1, ns2cyc(T_GAP_NS, CLK_NS));
  localparam int unsigned RD_CYC  = umax(1, ns2cyc(T_RD_NS, CLK_NS));
  localparam int unsigned ACC_CYC = umax(1, ns2cyc(T_ACC_NS, CLK_NS));
  localparam int unsigned REC_CYC = umax(1, ns2cyc(T_REC_NS, CLK_NS));
  localparam int unsigned MAX_CYC = umax(umax(umax(WR_CYC, GAP_CYC), umax(RD_CYC, ACC_CYC)),
                                         umax(REC_CYC, TMO_CYC));
  localparam int unsigned CW      = $clog2(MAX_CYC + 2);

  logic [1:0]    sync_q;
  logic          int_s, rdy_s;
  logic          clr, lat, lat_err, ro;
  logic [CW-1:0] cnt;

  adc_seq_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({adc_int_ni, adc_rdy_i}),
    .q_o   (sync_q)
  );

  assign int_s = sync_q[1];
  assign rdy_s = sync_q[0];

  adc_seq_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .cnt_o (cnt)
  );

  adc_seq_ctrl #(
    .CW     (CW),
    .WR_CYC (WR_CYC),
    .GAP_CYC(GAP_CYC),
    .RD_CYC (RD_CYC),
    .ACC_CYC(ACC_CYC),
    .REC_CYC(REC_CYC),
    .TMO_CYC(TMO_CYC)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .irq_wait_i(irq_wait_i),
    .int_ni    (int_s),
    .rdy_i     (rdy_s),
    .cnt_i     (cnt),
    .clr_o     (clr),
    .lat_o     (lat),
    .lat_err_o (lat_err),
    .ro_o      (ro),
    .busy_o    (busy_o),
    .cs_no     (adc_cs_no),
    .wr_no     (adc_wr_no),
    .rd_no     (adc_rd_no)
  );

  adc_seq_capture #(.DW(8)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lat_i    (lat),
    .lat_err_i(lat_err),
    .ro_i     (ro),
    .rdy_i    (rdy_s),
    .db_i     (adc_db_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .err_o    (err_o)
  );

  // pin-level run-length counters for the timing checks
  logic [CW-1:0] wr_run_q, gap_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_run_q  <= '0;
      gap_run_q <= '0;
    end else begin
      wr_run_q  <= !adc_wr_no ? ((&wr_run_q) ? wr_run_q : wr_run_q + 1'b1) : '0;
      gap_run_q <= !adc_wr_no ? '0 : ((&gap_run_q) ? gap_run_q : gap_run_q + 1'b1);
    end
  end

  AST_WR_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_wr_no) |-> (wr_run_q == CW'(WR_CYC))); // R4

  AST_RD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_rd_no) && !ro) |-> (gap_run_q >= CW'(GAP_CYC))); // R5

  AST_CS_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_wr_no || !adc_rd_no) |-> !adc_cs_no); // R2

  AST_IDLE_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (adc_cs_no && adc_wr_no && adc_rd_no)); // R10

endmodule

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;

  localparam int CLK_NS = 8;
  localparam int S      = 2;
  localparam int WR_C   = (600 + CLK_NS - 1) / CLK_NS;
  localparam int GAP_C  = (600 + CLK_NS - 1) / CLK_NS;
  localparam int RD_C   = (1600 + CLK_NS - 1) / CLK_NS;
  localparam int ACC_C  = (200 + CLK_NS - 1) / CLK_NS;
  localparam int REC_C  = (100 + CLK_NS - 1) / CLK_NS;
  localparam int TMO    = 400;
  localparam int NEVER  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b0, irq_wait_i = 1'b0, start_i = 1'b0;
  logic       busy_o, valid_o, err_o;
  logic [7:0] data_o;
  logic       adc_cs_n, adc_wr_n, adc_rd_n;
  logic       adc_int_n = 1'b1, adc_rdy = 1'b1;
  logic [7:0] adc_db = 8'h00;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  adc_seq #(
    .CLK_NS(CLK_NS), .T_RD_NS(1600), .T_WR_NS(600), .T_GAP_NS(600),
    .T_ACC_NS(200), .T_REC_NS(100), .TMO_CYC(TMO), .SYNC_STAGES(S)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .irq_wait_i(irq_wait_i),
    .start_i(start_i), .busy_o(busy_o), .data_o(data_o), .valid_o(valid_o),
    .err_o(err_o), .adc_cs_no(adc_cs_n), .adc_wr_no(adc_wr_n), .adc_rd_no(adc_rd_n),
    .adc_int_ni(adc_int_n), .adc_rdy_i(adc_rdy), .adc_db_i(adc_db)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model configuration
  bit         m_int_en = 1'b1;
  int         m_d = 1;
  logic [7:0] m_val = 8'h00;
  int         m_cnt = 0;

  always @(negedge clk) begin
    if (!mode_i) begin
      if (!adc_rd_n) begin
        m_cnt++;
        if (m_cnt >= m_d) begin
          adc_rdy = 1'b1;
          adc_db  = m_val;
          if (m_int_en) adc_int_n = 1'b0;
        end else adc_rdy = 1'b0;
      end else begin
        m_cnt = 0; adc_int_n = 1'b1; adc_rdy = 1'b1; adc_db = 8'h00;
      end
    end else begin
      adc_rdy = 1'b1;
      if (adc_cs_n || !adc_wr_n) m_cnt = 0;
      else if (adc_rd_n) begin
        m_cnt++;
        if (m_int_en && m_cnt >= m_d) adc_int_n = 1'b0;
      end
      if (!adc_rd_n) begin adc_int_n = 1'b1; adc_db = m_val; end
      else adc_db = 8'h00;
    end
  end

  // strobe monitor
  bit prev_wr = 1'b1, prev_rd = 1'b1;
  int wrun = 0, since = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_wr_n) begin
        if (prev_wr) begin
          chk(mode_i == 1'b1, "R2", "write strobe in read-only mode", 0, 1);
          chk(!adc_cs_n, "R2", "cs low at write fall", adc_cs_n, 0);
        end
        wrun++;
      end else if (!prev_wr) begin
        chk(wrun == WR_C, "R4", "write strobe width", wrun, WR_C);
        wrun = 0; since = 0;
      end
      if (adc_wr_n && adc_rd_n) since++;
      if (!adc_rd_n && prev_rd) begin
        chk(!adc_cs_n, "R2", "cs low at read fall", adc_cs_n, 0);
        if (mode_i) chk(since >= GAP_C, "R5", "write rise to read fall", since, GAP_C);
      end
      prev_wr = adc_wr_n;
      prev_rd = adc_rd_n;
    end
  end

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // expected cycles from start acceptance to the valid sample
  function automatic int exp_lat(bit md, bit iw, bit ie, int d, output bit er);
    int k;
    er = 1'b0;
    if (!md) begin
      k = ie ? (d - 1 + S) : imax(d - 1 + S, RD_C - 1);
      if (k > TMO - 1) begin k = TMO - 1; er = 1'b1; end
      return k + 1;
    end
    if (!iw)     k = GAP_C - 1;
    else if (ie) k = imax(d - 1 + S, GAP_C - 1);
    else         k = NEVER;
    if (iw && k > TMO - 1) begin k = TMO - 1; er = 1'b1; end
    return WR_C + k + 1 + ACC_C;
  endfunction

  task automatic run_conv(bit md, bit iw, bit ie, int d, logic [7:0] val, bit poke);
    int  lat_e, got = 0, idle_at = 0;
    bit  er_e;
    bit  got_err = 1'b0;
    logic [7:0] got_dat = 8'h00;
    string rq;
    lat_e = exp_lat(md, iw, ie, d, er_e);
    rq = er_e ? "R9" : (!md ? "R3" : (iw ? "R6" : "R7"));
    @(negedge clk);
    mode_i = md; irq_wait_i = iw; m_int_en = ie; m_d = d; m_val = val;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
    chk(adc_cs_n == 1'b0 && (md || adc_rd_n == 1'b0), "R2", "strobes after start", adc_cs_n, 0);
    for (int n = 1; n < 3000; n++) begin
      @(posedge clk);
      @(negedge clk);
      start_i = (poke && n == 1) ? 1'b1 : 1'b0;
      if (got == 0 && valid_o) begin
        got = n; got_dat = data_o; got_err = err_o;
      end else if (got != 0 && n == got + 1) begin
        chk(valid_o == 1'b0, "R8", "valid one cycle", valid_o, 0);
      end
      if (got != 0 && idle_at == 0 && !busy_o) idle_at = n;
      if (idle_at != 0 && n == idle_at + 3) begin
        chk(!busy_o && !valid_o, poke ? "R11" : "R10", "quiet after recovery",
            {busy_o, valid_o}, 0);
        break;
      end
    end
    chk(got == lat_e, rq, "latency to valid", got, lat_e);
    chk(got_err == er_e, "R9", "error flag", got_err, er_e);
    if (!er_e) chk(got_dat == val, "R8", "data", got_dat, val);
    chk(idle_at == got + REC_C, "R10", "recovery length", idle_at - got, REC_C);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1", "strobes in reset", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    chk(!busy_o && !valid_o && !err_o, "R1", "flags in reset", {busy_o, valid_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n && !busy_o, "R1", "idle after reset",
        {adc_cs_n, adc_wr_n, adc_rd_n, busy_o}, 14);

    // directed corners
    run_conv(1'b0, 1'b0, 1'b1, 3,     8'hA5, 1'b0); // R3 early end-of-conversion
    run_conv(1'b0, 1'b0, 1'b0, 10,    8'h3C, 1'b0); // R3 minimum read time path
    run_conv(1'b0, 1'b0, 1'b0, 250,   8'h81, 1'b0); // R3 ready late, no interrupt
    run_conv(1'b0, 1'b0, 1'b0, NEVER, 8'h00, 1'b0); // R9 read-only timeout
    run_conv(1'b1, 1'b0, 1'b1, 5,     8'h5A, 1'b0); // R5 fixed delay
    run_conv(1'b1, 1'b1, 1'b1, 200,   8'hC3, 1'b0); // R6 interrupt-driven
    run_conv(1'b1, 1'b1, 1'b1, 2,     8'h7E, 1'b0); // R6 early interrupt held to gap
    run_conv(1'b1, 1'b1, 1'b0, 1,     8'h11, 1'b0); // R9 write-then-read timeout
    run_conv(1'b0, 1'b0, 1'b1, 40,    8'hF0, 1'b1); // R11 start while busy
    run_conv(1'b1, 1'b0, 1'b1, 40,    8'h0F, 1'b1); // R11 start while busy

    for (int i = 0; i < 110; i++) begin
      bit md, iw, ie, pk;
      int d, cat;
      md  = 1'($urandom);
      iw  = 1'($urandom);
      pk  = ($urandom % 4) == 0;
      cat = $urandom % 8;
      ie  = (cat != 7);
      case (cat)
        0, 1, 2: d = 1 + ($urandom % 60);
        3, 4:    d = 60 + ($urandom % 190);
        5, 6:    d = 250 + ($urandom % 130);
        default: d = (md || ($urandom % 2)) ? NEVER : 1 + ($urandom % 300);
      endcase
      run_conv(md, iw, ie, d, 8'($urandom), pk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule